// File: doc/BRIEF.md
# Banker's Safe-Allocation Checker

This block keeps the resource bookkeeping for a fixed group of processes that share several counted resource types. It stores one free-count vector for the whole system and, for each process, the units it currently holds and the units it may still ask for. A requester presents a process index and a vector of wanted units. The block refuses the request outright when it overruns the process's declared claim. It defers the request when there are too few free units. Otherwise it books the units tentatively and then proves, with a step-by-step search over the processes, that every process could still run to completion.

If the search finishes every process, the booking stands, the answer is grant, and the completion order found is published. If the search stalls, the booking is undone and the answer is wait. A release port hands held units back. A load port sets the free pool or a process's total claim. The search takes one clock per candidate. While it runs, a busy flag is raised and every port is ignored.

Top module: `banker_checker`

## Requirements
- R1: After synchronous reset, busy and rsp_valid are low, avail_vec and safe_seq are zero, and every process holds nothing and may claim nothing.
- R2: An accepted load with ld_sel=0 sets the free pool to ld_vec. With ld_sel=1 it sets the remaining claim of process ld_pid to ld_vec minus its held units, and it is ignored if ld_vec is below the held units in any element. The change is visible one cycle after acceptance.
- R3: A request with any element above the process's remaining claim gives rsp_code 2 (error) one cycle after acceptance, and it changes no state.
- R4: A request within the claim but above the free pool in any element gives rsp_code 1 (wait) one cycle after acceptance, and it changes no state.
- R5: A request within both the claim and the free pool is booked tentatively: the free pool drops by the request, the holding rises, and the remaining claim drops. busy is high in the cycle after acceptance.
- R6: The search starts from the post-booking free pool with no process finished. It visits indices lowest first, in repeated passes. A process is finished when its remaining claim fits the working pool in every element, and its holding is then added to that pool.
- R7: If every process finishes, rsp_code is 0 (grant) and the booking stays. safe_seq then holds the finish order, with entry k (the k-th finished index) at bits [k*PIDW +: PIDW].
- R8: If a pass ends with no new process finished and some are unfinished, rsp_code is 1 (wait), and the free pool, holding and claim return to their values from before the request.
- R9: busy lasts at most N_PROC*N_PROC+2 cycles. Request, release and load inputs presented while busy are ignored.
- R10: A release no larger than the process's holding in every element adds rel_vec to the free pool and moves it from holding back to remaining claim. A larger release is ignored.
- R11: When idle, a request outranks a release, and a release outranks a load. Lower-ranked inputs in the same cycle are dropped.
- R12: rsp_valid is a one-cycle pulse for each accepted request and is never high together with busy. safe_seq changes only on a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_pid | input | PIDW | Requesting process |
| req_vec | input | N_RES*CW | Wanted units, element r at bits [r*CW +: CW] |
| rel_valid | input | 1 | Release strobe |
| rel_pid | input | PIDW | Releasing process |
| rel_vec | input | N_RES*CW | Returned units |
| ld_valid | input | 1 | Load strobe |
| ld_sel | input | 1 | 0: free pool, 1: process claim |
| ld_pid | input | PIDW | Process for a claim load |
| ld_vec | input | N_RES*CW | Loaded vector |
| busy | output | 1 | Safety search in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | 0 grant, 1 wait, 2 error |
| safe_seq | output | N_PROC*PIDW | Finish order of the last grant |
| avail_vec | output | N_RES*CW | Current free pool |

## Verification
Every process is swept against every request vector with elements 0 to 3 from a realistic mixed holding. Each grant is released again, so the same state is probed each time. This separates over-claim errors, plain shortages, unsafe bookings that must roll back, and grants whose finish order depends on the lowest-first multi-pass scan. A second sweep from a starved pool drives most requests into shortage or rollback. Targeted cases pit request, release and load against each other in one cycle, present inputs while busy, and try releases and claim loads that must be ignored.

// File: rtl/banker_pkg.sv
package banker_pkg;
  typedef enum logic [1:0] {
    RSP_GRANT = 2'd0,
    RSP_WAIT  = 2'd1,
    RSP_ERROR = 2'd2
  } rsp_e;
endpackage

// File: rtl/banker_vec_le.sv
// Element-wise "lhs <= rhs" over packed count vectors.
module banker_vec_le #(
  parameter int N_RES = 3,
  parameter int W     = 4
) (
  input  logic [N_RES*W-1:0] lhs,
  input  logic [N_RES*W-1:0] rhs,
  output logic               le
);
  logic [N_RES-1:0] elem_ok;
  for (genvar r = 0; r < N_RES; r++) begin : g_elem
    assign elem_ok[r] = lhs[r*W +: W] <= rhs[r*W +: W];
  end
  assign le = &elem_ok;
endmodule

// File: rtl/banker_scan.sv
// Sequential safety search: one candidate process per clock, repeated passes.
module banker_scan #(
  parameter int N_PROC = 4,
  parameter int N_RES  = 3,
  parameter int CW     = 4,
  parameter int WW     = 7,
  localparam int PIDW  = (N_PROC > 1) ? $clog2(N_PROC) : 1,
  localparam int ROWW  = N_RES * CW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [N_RES*WW-1:0]    start_work,
  input  logic [N_PROC*ROWW-1:0] need_all,
  input  logic [N_PROC*ROWW-1:0] alloc_all,
  output logic                   done,
  output logic                   safe,
  output logic [N_PROC*PIDW-1:0] seq
);
  localparam int CNTW = $clog2(N_PROC + 1);

  logic                 running;
  logic [N_RES*WW-1:0]  work;
  logic [N_PROC-1:0]    finish;
  logic [PIDW-1:0]      idx;
  logic                 progress;
  logic [CNTW-1:0]      cnt;
  logic [PIDW-1:0]      seq_q [N_PROC];

  logic [ROWW-1:0]      need_row  [N_PROC];
  logic [ROWW-1:0]      alloc_row [N_PROC];
  logic [N_RES*WW-1:0]  cand_need_ext, cand_alloc_ext, work_sum;
  logic [N_PROC-1:0]    idx_onehot, next_finish;
  logic                 fits, eligible, last;

  for (genvar p = 0; p < N_PROC; p++) begin : g_rows
    assign need_row[p]  = need_all[p*ROWW +: ROWW];
    assign alloc_row[p] = alloc_all[p*ROWW +: ROWW];
    assign seq[p*PIDW +: PIDW] = seq_q[p];
  end

  for (genvar r = 0; r < N_RES; r++) begin : g_ext
    assign cand_need_ext[r*WW +: WW]  = {{(WW-CW){1'b0}}, need_row[idx][r*CW +: CW]};
    assign cand_alloc_ext[r*WW +: WW] = {{(WW-CW){1'b0}}, alloc_row[idx][r*CW +: CW]};
    assign work_sum[r*WW +: WW]       = work[r*WW +: WW] + cand_alloc_ext[r*WW +: WW];
  end

  banker_vec_le #(.N_RES(N_RES), .W(WW)) u_fit (
    .lhs(cand_need_ext), .rhs(work), .le(fits)
  );

  always_comb begin
    idx_onehot      = '0;
    idx_onehot[idx] = 1'b1;
  end

  assign eligible    = running && !finish[idx] && fits;
  assign next_finish = eligible ? (finish | idx_onehot) : finish;
  assign last        = (idx == PIDW'(N_PROC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      done     <= 1'b0;
      safe     <= 1'b0;
      work     <= '0;
      finish   <= '0;
      idx      <= '0;
      progress <= 1'b0;
      cnt      <= '0;
      for (int p = 0; p < N_PROC; p++) seq_q[p] <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running  <= 1'b1;
        work     <= start_work;
        finish   <= '0;
        idx      <= '0;
        progress <= 1'b0;
        cnt      <= '0;
      end else if (running) begin
        if (eligible) begin
          work                     <= work_sum;
          finish                   <= next_finish;
          seq_q[cnt[PIDW-1:0]]     <= idx;
          cnt                      <= cnt + 1'b1;
        end
        if (last) begin
          if (&next_finish) begin
            running <= 1'b0;
            done    <= 1'b1;
            safe    <= 1'b1;
          end else if (!(progress || eligible)) begin
            running <= 1'b0;
            done    <= 1'b1;
            safe    <= 1'b0;
          end else begin
            idx      <= '0;
            progress <= 1'b0;
          end
        end else begin
          idx      <= idx + 1'b1;
          progress <= progress || eligible;
        end
      end
    end
  end

  // R6: a finished process never becomes unfinished during a search
  p_finish_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
    (running && !start) |=> (($past(finish) & ~finish) == '0));

  // R9: the completion pulse only appears once the search has stopped
  p_done_stops_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !running);
endmodule

// File: rtl/banker_checker.sv
module banker_checker #(
  parameter int N_PROC = 4,
  parameter int N_RES  = 3,
  parameter int CW     = 4,
  localparam int PIDW  = (N_PROC > 1) ? $clog2(N_PROC) : 1,
  localparam int ROWW  = N_RES * CW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [PIDW-1:0]        req_pid,
  input  logic [ROWW-1:0]        req_vec,
  input  logic                   rel_valid,
  input  logic [PIDW-1:0]        rel_pid,
  input  logic [ROWW-1:0]        rel_vec,
  input  logic                   ld_valid,
  input  logic                   ld_sel,
  input  logic [PIDW-1:0]        ld_pid,
  input  logic [ROWW-1:0]        ld_vec,
  output logic                   busy,
  output logic                   rsp_valid,
  output logic [1:0]             rsp_code,
  output logic [N_PROC*PIDW-1:0] safe_seq,
  output logic [ROWW-1:0]        avail_vec
);
  import banker_pkg::*;

  localparam int WW       = CW + $clog2(N_PROC + 1);
  localparam int BUSY_MAX = N_PROC * N_PROC + 2;
  localparam int BCW      = $clog2(BUSY_MAX + 2);

  typedef enum logic {ST_IDLE, ST_SCAN} st_e;

  st_e             state;
  rsp_e            rsp_q;
  logic [ROWW-1:0] avail_q;
  logic [ROWW-1:0] alloc_q [N_PROC];
  logic [ROWW-1:0] need_q  [N_PROC];
  logic [PIDW-1:0] hold_pid;
  logic [ROWW-1:0] hold_vec;

  logic idle, take_req, take_rel, take_ld;
  logic req_in_claim, req_in_pool, rel_ok, ld_ok;
  logic [ROWW-1:0] avail_minus_req, alloc_plus_req, need_minus_req;
  logic [ROWW-1:0] avail_plus_rel, alloc_minus_rel, need_plus_rel;
  logic [ROWW-1:0] claim_need;
  logic [ROWW-1:0] avail_back, alloc_back, need_back;
  logic [N_RES*WW-1:0]  start_work;
  logic [N_PROC*ROWW-1:0] need_all, alloc_all;
  logic scan_go, scan_done, scan_safe;
  logic [N_PROC*PIDW-1:0] scan_seq;

  assign idle     = (state == ST_IDLE);
  assign take_req = idle && req_valid;
  assign take_rel = idle && !req_valid && rel_valid;
  assign take_ld  = idle && !req_valid && !rel_valid && ld_valid;

  banker_vec_le #(.N_RES(N_RES), .W(CW)) u_req_claim (
    .lhs(req_vec), .rhs(need_q[req_pid]), .le(req_in_claim));
  banker_vec_le #(.N_RES(N_RES), .W(CW)) u_req_pool (
    .lhs(req_vec), .rhs(avail_q), .le(req_in_pool));
  banker_vec_le #(.N_RES(N_RES), .W(CW)) u_rel_held (
    .lhs(rel_vec), .rhs(alloc_q[rel_pid]), .le(rel_ok));
  banker_vec_le #(.N_RES(N_RES), .W(CW)) u_ld_claim (
    .lhs(alloc_q[ld_pid]), .rhs(ld_vec), .le(ld_ok));

  always_comb begin
    for (int r = 0; r < N_RES; r++) begin
      avail_minus_req[r*CW +: CW] = avail_q[r*CW +: CW] - req_vec[r*CW +: CW];
      alloc_plus_req[r*CW +: CW]  = alloc_q[req_pid][r*CW +: CW] + req_vec[r*CW +: CW];
      need_minus_req[r*CW +: CW]  = need_q[req_pid][r*CW +: CW] - req_vec[r*CW +: CW];
      avail_plus_rel[r*CW +: CW]  = avail_q[r*CW +: CW] + rel_vec[r*CW +: CW];
      alloc_minus_rel[r*CW +: CW] = alloc_q[rel_pid][r*CW +: CW] - rel_vec[r*CW +: CW];
      need_plus_rel[r*CW +: CW]   = need_q[rel_pid][r*CW +: CW] + rel_vec[r*CW +: CW];
      claim_need[r*CW +: CW]      = ld_vec[r*CW +: CW] - alloc_q[ld_pid][r*CW +: CW];
      avail_back[r*CW +: CW]      = avail_q[r*CW +: CW] + hold_vec[r*CW +: CW];
      alloc_back[r*CW +: CW]      = alloc_q[hold_pid][r*CW +: CW] - hold_vec[r*CW +: CW];
      need_back[r*CW +: CW]       = need_q[hold_pid][r*CW +: CW] + hold_vec[r*CW +: CW];
    end
  end

  for (genvar r = 0; r < N_RES; r++) begin : g_work
    assign start_work[r*WW +: WW] = {{(WW-CW){1'b0}}, avail_minus_req[r*CW +: CW]};
  end
  for (genvar p = 0; p < N_PROC; p++) begin : g_flat
    assign need_all[p*ROWW +: ROWW]  = need_q[p];
    assign alloc_all[p*ROWW +: ROWW] = alloc_q[p];
  end

  assign scan_go = take_req && req_in_claim && req_in_pool;

  banker_scan #(.N_PROC(N_PROC), .N_RES(N_RES), .CW(CW), .WW(WW)) u_scan (
    .clk(clk), .rst(rst), .start(scan_go), .start_work(start_work),
    .need_all(need_all), .alloc_all(alloc_all),
    .done(scan_done), .safe(scan_safe), .seq(scan_seq));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_q     <= RSP_GRANT;
      rsp_valid <= 1'b0;
      safe_seq  <= '0;
      avail_q   <= '0;
      hold_pid  <= '0;
      hold_vec  <= '0;
      for (int p = 0; p < N_PROC; p++) begin
        alloc_q[p] <= '0;
        need_q[p]  <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take_req) begin
            if (!req_in_claim) begin
              rsp_valid <= 1'b1;
              rsp_q     <= RSP_ERROR;
            end else if (!req_in_pool) begin
              rsp_valid <= 1'b1;
              rsp_q     <= RSP_WAIT;
            end else begin
              avail_q          <= avail_minus_req;
              alloc_q[req_pid] <= alloc_plus_req;
              need_q[req_pid]  <= need_minus_req;
              hold_pid         <= req_pid;
              hold_vec         <= req_vec;
              state            <= ST_SCAN;
            end
          end else if (take_rel) begin
            if (rel_ok) begin
              avail_q          <= avail_plus_rel;
              alloc_q[rel_pid] <= alloc_minus_rel;
              need_q[rel_pid]  <= need_plus_rel;
            end
          end else if (take_ld) begin
            if (!ld_sel) avail_q <= ld_vec;
            else if (ld_ok) need_q[ld_pid] <= claim_need;
          end
        end
        ST_SCAN: begin
          if (scan_done) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            if (scan_safe) begin
              rsp_q    <= RSP_GRANT;
              safe_seq <= scan_seq;
            end else begin
              rsp_q             <= RSP_WAIT;
              avail_q           <= avail_back;
              alloc_q[hold_pid] <= alloc_back;
              need_q[hold_pid]  <= need_back;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state == ST_SCAN);
  assign rsp_code  = rsp_q;
  assign avail_vec = avail_q;

  // Busy-length counter kept for the bound check only
  logic [BCW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
  end

  p_scan_bounded_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt <= BCW'(BUSY_MAX)));

  p_pool_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(avail_q));

  p_error_no_change_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_q == RSP_ERROR) |-> $stable(avail_q));

  p_rsp_not_busy_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  p_seq_only_on_grant_r12: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_q == RSP_GRANT) |-> $stable(safe_seq));
endmodule

// File: tb/test_banker_checker.sv
module test_banker_checker;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NR = 3;
  localparam int CW = 4;
  localparam int PW = 2;
  localparam int RW = NR * CW;

  logic clk, rst;
  logic req_valid, rel_valid, ld_valid, ld_sel;
  logic [PW-1:0] req_pid, rel_pid, ld_pid;
  logic [RW-1:0] req_vec, rel_vec, ld_vec;
  logic busy, rsp_valid;
  logic [1:0] rsp_code;
  logic [NP*PW-1:0] safe_seq;
  logic [RW-1:0] avail_vec;

  banker_checker #(.N_PROC(NP), .N_RES(NR), .CW(CW)) i_banker_checker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_pid(req_pid), .req_vec(req_vec),
    .rel_valid(rel_valid), .rel_pid(rel_pid), .rel_vec(rel_vec),
    .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_pid(ld_pid), .ld_vec(ld_vec),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .safe_seq(safe_seq), .avail_vec(avail_vec));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  int m_av [NR];
  int m_al [NP][NR];
  int m_nd [NP][NR];
  logic [NP*PW-1:0] m_seq;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] vec3(input int a, input int b, input int c);
    logic [RW-1:0] v;
    v[3:0] = a[3:0]; v[7:4] = b[3:0]; v[11:8] = c[3:0];
    return v;
  endfunction

  function automatic logic [RW-1:0] pool_exp();
    return vec3(m_av[0], m_av[1], m_av[2]);
  endfunction

  // Model: code 0 grant, 1 shortage, 2 over-claim, 3 unsafe rollback
  task automatic model_req(input int pid, input logic [RW-1:0] v,
                           output int code, output logic [NP*PW-1:0] seq);
    int rq [NR]; int w [NR]; bit fin [NP];
    int cnt; bit prog, fits, ok_n, ok_a;
    seq = m_seq; code = 0; ok_n = 1; ok_a = 1;
    for (int r = 0; r < NR; r++) begin
      rq[r] = int'(v[r*CW +: CW]);
      if (rq[r] > m_nd[pid][r]) ok_n = 0;
      if (rq[r] > m_av[r]) ok_a = 0;
    end
    if (!ok_n) begin code = 2; return; end
    if (!ok_a) begin code = 1; return; end
    for (int r = 0; r < NR; r++) begin
      m_av[r] -= rq[r]; m_al[pid][r] += rq[r]; m_nd[pid][r] -= rq[r];
      w[r] = m_av[r];
    end
    for (int i = 0; i < NP; i++) fin[i] = 0;
    cnt = 0;
    for (int pass = 0; pass < NP; pass++) begin
      prog = 0;
      for (int i = 0; i < NP; i++) begin
        if (!fin[i]) begin
          fits = 1;
          for (int r = 0; r < NR; r++) if (m_nd[i][r] > w[r]) fits = 0;
          if (fits) begin
            for (int r = 0; r < NR; r++) w[r] += m_al[i][r];
            fin[i] = 1;
            seq[cnt*PW +: PW] = PW'(i);
            cnt++;
            prog = 1;
          end
        end
      end
      if (cnt == NP || !prog) break;
    end
    if (cnt == NP) begin
      m_seq = seq;
    end else begin
      code = 3;
      seq = m_seq;
      for (int r = 0; r < NR; r++) begin
        m_av[r] += rq[r]; m_al[pid][r] -= rq[r]; m_nd[pid][r] += rq[r];
      end
    end
  endtask

  task automatic do_req(input int pid, input logic [RW-1:0] v, input bit poke, output int code);
    logic [NP*PW-1:0] eseq;
    int waited, busy_n, exp_code;
    string tag;
    model_req(pid, v, code, eseq);
    tag = (code == 0) ? "R7" : (code == 1) ? "R4" : (code == 2) ? "R3" : "R8";
    exp_code = (code == 3) ? 1 : code;
    @(negedge clk);
    req_valid = 1'b1; req_pid = PW'(pid); req_vec = v;
    @(negedge clk);
    req_valid = 1'b0;
    if (code == 0 || code == 3) chk(busy == 1'b1, "R5 busy after booking", busy, 1);
    if (poke) begin
      // R9: these must be ignored while the search runs
      rel_valid = 1'b1; rel_pid = 2'd3; rel_vec = vec3(1, 0, 0);
      ld_valid = 1'b1; ld_sel = 1'b0; ld_vec = vec3(0, 0, 0);
    end
    waited = 0; busy_n = 0;
    while (!rsp_valid && waited < 60) begin
      if (busy) busy_n++;
      @(negedge clk);
      rel_valid = 1'b0; ld_valid = 1'b0;
      waited++;
    end
    chk(rsp_valid == 1'b1, {tag, " response present"}, rsp_valid, 1);
    chk(rsp_code == 2'(exp_code), {tag, " response code"}, rsp_code, exp_code);
    chk(avail_vec == pool_exp(), {tag, " free pool"}, avail_vec, pool_exp());
    chk(safe_seq == eseq, (code == 0) ? "R6 finish order" : "R12 order held", safe_seq, eseq);
    if (busy_n > 0) chk(busy_n <= NP*NP + 2, "R9 busy bound", busy_n, NP*NP + 2);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 single pulse", rsp_valid, 0);
  endtask

  task automatic do_rel(input int pid, input logic [RW-1:0] v);
    bit ok = 1;
    for (int r = 0; r < NR; r++) if (int'(v[r*CW +: CW]) > m_al[pid][r]) ok = 0;
    if (ok) for (int r = 0; r < NR; r++) begin
      m_av[r] += int'(v[r*CW +: CW]);
      m_al[pid][r] -= int'(v[r*CW +: CW]);
      m_nd[pid][r] += int'(v[r*CW +: CW]);
    end
    @(negedge clk);
    rel_valid = 1'b1; rel_pid = PW'(pid); rel_vec = v;
    @(negedge clk);
    rel_valid = 1'b0;
    chk(avail_vec == pool_exp(), "R10 release", avail_vec, pool_exp());
  endtask

  task automatic do_ld(input bit sel, input int pid, input logic [RW-1:0] v);
    bit ok = 1;
    if (!sel) begin
      for (int r = 0; r < NR; r++) m_av[r] = int'(v[r*CW +: CW]);
    end else begin
      for (int r = 0; r < NR; r++) if (int'(v[r*CW +: CW]) < m_al[pid][r]) ok = 0;
      if (ok) for (int r = 0; r < NR; r++) m_nd[pid][r] = int'(v[r*CW +: CW]) - m_al[pid][r];
    end
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_pid = PW'(pid); ld_vec = v;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(avail_vec == pool_exp(), "R2 load", avail_vec, pool_exp());
  endtask

  initial begin
    int code;
    rst = 1'b1;
    req_valid = 0; rel_valid = 0; ld_valid = 0; ld_sel = 0;
    req_pid = '0; rel_pid = '0; ld_pid = '0;
    req_vec = '0; rel_vec = '0; ld_vec = '0;
    for (int r = 0; r < NR; r++) m_av[r] = 0;
    for (int p = 0; p < NP; p++) for (int r = 0; r < NR; r++) begin
      m_al[p][r] = 0; m_nd[p][r] = 0;
    end
    m_seq = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(rsp_valid == 1'b0, "R1 response after reset", rsp_valid, 0);
    chk(avail_vec == '0, "R1 pool after reset", avail_vec, 0);
    chk(safe_seq == '0, "R1 order after reset", safe_seq, 0);
    // R1: zero claims mean any nonzero request is an over-claim
    do_req(0, vec3(1, 0, 0), 1'b0, code);

    // R2: configure pool and claims
    do_ld(1'b0, 0, vec3(10, 5, 7));
    do_ld(1'b1, 0, vec3(7, 5, 3));
    do_ld(1'b1, 1, vec3(3, 2, 2));
    do_ld(1'b1, 2, vec3(9, 0, 2));
    do_ld(1'b1, 3, vec3(2, 2, 2));
    do_req(1, vec3(2, 0, 0), 1'b0, code);
    do_req(2, vec3(3, 0, 2), 1'b0, code);
    do_req(3, vec3(2, 1, 1), 1'b0, code);
    do_req(0, vec3(0, 1, 0), 1'b0, code);
    // R2: claim below current holding is ignored; probe via request
    do_ld(1'b1, 2, vec3(1, 0, 0));
    do_req(2, vec3(6, 0, 0), 1'b0, code);
    // R10: release larger than holding is ignored
    do_rel(0, vec3(5, 0, 0));

    // R5 R6 R7 R8: full sweep, each grant handed back
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++) begin
            do_req(p, vec3(a, b, c), 1'b0, code);
            if (code == 0) do_rel(p, vec3(a, b, c));
          end

    // Starved pool sweep
    do_ld(1'b0, 0, vec3(1, 1, 1));
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          for (int c = 0; c < 2; c++) begin
            do_req(p, vec3(a, b, c), 1'b0, code);
            if (code == 0) do_rel(p, vec3(a, b, c));
          end

    // R11: request beats release in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_pid = 2'd0; req_vec = vec3(15, 15, 15);
    rel_valid = 1'b1; rel_pid = 2'd1; rel_vec = vec3(1, 0, 0);
    @(negedge clk);
    req_valid = 1'b0; rel_valid = 1'b0;
    chk(rsp_valid == 1'b1 && rsp_code == 2'd2, "R11 request wins", rsp_code, 2);
    chk(avail_vec == pool_exp(), "R11 release dropped", avail_vec, pool_exp());
    // R11: release beats load in the same cycle
    for (int r = 0; r < NR; r++) begin
      m_av[r] += (r == 0) ? 1 : 0;
    end
    m_al[1][0] -= 1; m_nd[1][0] += 1;
    @(negedge clk);
    rel_valid = 1'b1; rel_pid = 2'd1; rel_vec = vec3(1, 0, 0);
    ld_valid = 1'b1; ld_sel = 1'b0; ld_vec = vec3(0, 0, 0);
    @(negedge clk);
    rel_valid = 1'b0; ld_valid = 1'b0;
    chk(avail_vec == pool_exp(), "R11 load dropped", avail_vec, pool_exp());

    // R9: release and load presented while busy are ignored
    do_req(1, vec3(1, 0, 0), 1'b1, code);
    chk(avail_vec == pool_exp(), "R9 inputs ignored while busy", avail_vec, pool_exp());
    do_req(3, vec3(0, 0, 0), 1'b0, code);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule